// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a purely combinational 32-bit arithmetic logic unit for an integer execution stage. It takes two operands and a 3-bit operation select. It returns a 32-bit result together with three status outputs: zero, signed overflow and adder carry-out. It performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than.

A single adder serves every arithmetic operation. The high bit of the operation select inverts the second operand and also feeds the adder's carry-in, so subtraction is computed as A + ~B + 1. The signed comparison is read from the subtraction's sign, corrected by its overflow condition. The resulting bit is placed in bit 0 of the result.

Equality is tested by subtracting and looking at the zero flag. Overflow is only reported as a flag. Nothing traps on it.

Top module: `int_alu`

## Requirements
- R1: Select 3'b000 gives the bitwise AND of A and B.
- R2: Select 3'b001 gives the bitwise OR of A and B.
- R3: Select 3'b010 gives A + B modulo 2^32. Carry-out is bit 32 of the unsigned sum.
- R4: Select 3'b110 gives A - B, computed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers (no borrow).
- R5: Select 3'b111 gives 32'h1 when A < B as signed numbers and 32'h0 otherwise. The comparison is correct even when A - B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every select value.
- R7: For addition, overflow is 1 when two non-negative operands give a negative result, or two negative operands give a non-negative result.
- R8: For subtraction, overflow is 1 when a non-negative minus a negative gives a negative result, or a negative minus a non-negative gives a non-negative result.
- R9: Addition of operands with opposite signs never flags overflow. Subtraction of operands with the same sign never flags overflow.
- R10: The unused selects 3'b011, 3'b100 and 3'b101 give a zero result, with overflow and carry-out both 0.
- R11: For AND, OR and set-on-less-than, overflow and carry-out are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when the result is all zeros |
| overflowFlag | output | 1 | Signed overflow of ADD or SUB |
| carryOut | output | 1 | Carry from the adder's top bit for ADD or SUB |

## Verification
The hardest case to reach is a set-on-less-than whose internal subtraction overflows. In that case the raw sign bit gives the wrong answer. The bench reaches it by comparing the most negative value against positive numbers, and the most positive value against negative numbers. The overflow boundaries themselves get the same treatment: sums and differences that land exactly one step past the signed range. A long pseudo-random sweep over all eight select codes then covers the ordinary cases.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_AND = 3'b000;
  localparam logic [OPW-1:0] OP_OR  = 3'b001;
  localparam logic [OPW-1:0] OP_ADD = 3'b010;
  localparam logic [OPW-1:0] OP_SUB = 3'b110;
  localparam logic [OPW-1:0] OP_SLT = 3'b111;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_SUM,
    SEL_LESS,
    SEL_NONE
  } resSel_e;

  typedef struct packed {
    logic    bNegate;
    resSel_e resSel;
    logic    flagEn;
  } aluCtrl_t;
endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OPW-1:0] opSel,
  output aluCtrl_t       ctrl
);
  always_comb begin
    // The top select bit inverts B and supplies the adder carry-in.
    ctrl.bNegate = opSel[OPW-1];
    ctrl.flagEn  = 1'b0;
    case (opSel)
      OP_AND: ctrl.resSel = SEL_AND;
      OP_OR:  ctrl.resSel = SEL_OR;
      OP_ADD: begin ctrl.resSel = SEL_SUM; ctrl.flagEn = 1'b1; end
      OP_SUB: begin ctrl.resSel = SEL_SUM; ctrl.flagEn = 1'b1; end
      OP_SLT: ctrl.resSel = SEL_LESS;
      default: ctrl.resSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic [WIDTH-1:0]  result,
  output logic              zeroFlag,
  output logic              overflowFlag,
  output logic              carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             adderCarry;
  logic             ovfRaw;
  logic             lessBit;

  always_comb begin
    bEff       = ctrl.bNegate ? ~opB : opB;
    sumWide    = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, ctrl.bNegate};
    sum        = sumWide[WIDTH-1:0];
    adderCarry = sumWide[WIDTH];
    // Overflow: both adder inputs share a sign that the sum does not.
    ovfRaw     = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
    // Correct the sign with the overflow so that the comparison survives it.
    lessBit    = sum[MSB] ^ ovfRaw;
  end

  always_comb begin
    case (ctrl.resSel)
      SEL_AND:  result = opA & opB;
      SEL_OR:   result = opA | opB;
      SEL_SUM:  result = sum;
      SEL_LESS: result = {{(WIDTH-1){1'b0}}, lessBit};
      default:  result = '0;
    endcase
    zeroFlag     = ~|result;
    overflowFlag = ctrl.flagEn & ovfRaw;
    carryOut     = ctrl.flagEn & adderCarry;
  end

  always_comb begin
    // R9
    if (ctrl.flagEn && !ctrl.bNegate && (opA[MSB] != opB[MSB]))
      opposite_sign_add_chk: assert (!overflowFlag)
        else $error("overflow flagged on opposite-sign add");
    // R9
    if (ctrl.flagEn && ctrl.bNegate && (opA[MSB] == opB[MSB]))
      same_sign_sub_chk: assert (!overflowFlag)
        else $error("overflow flagged on same-sign subtract");
    // R5
    if (ctrl.resSel == SEL_LESS)
      less_shape_chk: assert (result[WIDTH-1:1] == '0)
        else $error("compare result has upper bits set");
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OPW-1:0]   opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             carryOut
);
  aluCtrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  int_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctrl         (ctrl),
    .opA          (opA),
    .opB          (opB),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .overflowFlag (overflowFlag),
    .carryOut     (carryOut)
  );

  always_comb begin
    // R3
    if (opSel == OP_ADD)
      add_exact_chk: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}))
        else $error("add result or carry wrong");
    // R6
    if (opSel == OP_SUB)
      sub_equal_chk: assert (zeroFlag == (opA == opB))
        else $error("zero flag disagrees with equality on subtract");
    // R10
    if (opSel == 3'b011 || opSel == 3'b100 || opSel == 3'b101)
      unused_quiet_chk: assert (result == '0 && !overflowFlag && !carryOut)
        else $error("unused select produced output");
    // R11
    if (opSel == OP_AND || opSel == OP_OR || opSel == OP_SLT)
      logic_flags_chk: assert (!overflowFlag && !carryOut)
        else $error("flags raised on non-adder operation");
  end
endmodule

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]  opSel = 3'b000;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic zeroFlag, overflowFlag, carryOut;

  int_alu u0 (
    .opSel(opSel), .opA(opA), .opB(opB), .result(result),
    .zeroFlag(zeroFlag), .overflowFlag(overflowFlag), .carryOut(carryOut)
  );

  typedef struct {
    logic [31:0] expR;
    logic        expZ;
    logic        expO;
    logic        expC;
    string       tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit summaryDone = 0;

  function automatic string tagFor(logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3/R7";
      3'b110: return "R4/R8";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  // Driver: compute the expectation from the requirements, then apply it.
  task automatic send(logic [2:0] op, logic [31:0] a, logic [31:0] b, string tag);
    item_t it;
    logic [32:0] s33;
    longint sv;
    it.expO = 1'b0;
    it.expC = 1'b0;
    case (op)
      3'b000: it.expR = a & b;
      3'b001: it.expR = a | b;
      3'b010: begin
        s33 = {1'b0, a} + {1'b0, b};
        it.expR = s33[31:0];
        it.expC = s33[32];
        sv = longint'($signed(a)) + longint'($signed(b));
        it.expO = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      3'b110: begin
        it.expR = a - b;
        it.expC = (a >= b);
        sv = longint'($signed(a)) - longint'($signed(b));
        it.expO = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      3'b111: it.expR = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: it.expR = '0;
    endcase
    it.expZ = (it.expR == 32'd0);
    it.tag = tag;
    @(posedge clk);
    opSel = op;
    opA = a;
    opB = b;
    sb.push_back(it);
  endtask

  // Monitor: sample between edges and compare against the queue head.
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (result !== it.expR || zeroFlag !== it.expZ ||
          overflowFlag !== it.expO || carryOut !== it.expC) begin
        errors++;
        $display("FAIL %s op=%b a=%h b=%h: got r=%h z=%b o=%b c=%b, expected r=%h z=%b o=%b c=%b",
                 it.tag, opSel, opA, opB, result, zeroFlag, overflowFlag, carryOut,
                 it.expR, it.expZ, it.expO, it.expC);
      end
    end
  end

  initial begin
    #(5ns * 100000);
    if (!summaryDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      summaryDone = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: all-zero inputs with AND give zero result, R6 zero flag.
    send(3'b000, 32'h0, 32'h0, "R1 R6 reset");
    send(3'b000, 32'hF0F0_A5A5, 32'hFF00_0F0F, "R1");
    send(3'b001, 32'hF0F0_A5A5, 32'h0F00_5A5A, "R2");
    send(3'b001, 32'h0, 32'h0, "R2 R6");
    send(3'b010, 32'd1, 32'd2, "R3");
    send(3'b010, 32'hFFFF_FFFF, 32'd1, "R3 R6 carry");
    send(3'b010, 32'h7FFF_FFFF, 32'd1, "R7 pos+pos");
    send(3'b010, 32'h8000_0000, 32'h8000_0000, "R7 neg+neg");
    send(3'b010, 32'h8000_0000, 32'hFFFF_FFFF, "R7 neg+neg");
    send(3'b010, 32'd5, 32'hFFFF_FFFB, "R9 opposite-sign add");
    send(3'b010, 32'h7FFF_FFFF, 32'h8000_0000, "R9 opposite-sign add");
    send(3'b110, 32'd10, 32'd3, "R4");
    send(3'b110, 32'd3, 32'd10, "R4 borrow");
    send(3'b110, 32'd5, 32'd5, "R4 R6 equal");
    send(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8 pos-neg");
    send(3'b110, 32'h8000_0000, 32'd1, "R8 neg-pos");
    send(3'b110, 32'hFFFF_0000, 32'hFFFF_FFF0, "R9 same-sign sub");
    send(3'b110, 32'h7FFF_FFFF, 32'd0, "R9 same-sign sub");
    send(3'b111, 32'd3, 32'd10, "R5 R11");
    send(3'b111, 32'd10, 32'd3, "R5 R6");
    send(3'b111, 32'hFFFF_FFFF, 32'd1, "R5 signed");
    send(3'b111, 32'h8000_0000, 32'd1, "R5 overflowing compare");
    send(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, "R5 overflowing compare");
    send(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, "R5 overflowing compare");
    send(3'b111, 32'h1234_5678, 32'h1234_5678, "R5 equal");
    send(3'b011, 32'hFFFF_FFFF, 32'd1, "R10");
    send(3'b100, 32'h7FFF_FFFF, 32'd1, "R10");
    send(3'b101, 32'h8000_0000, 32'h8000_0000, "R10");
    send(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 and");
    send(3'b001, 32'h8000_0000, 32'h8000_0000, "R11 or");
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = (i % 5 == 0) ? a : seed;
      if (i % 7 == 0) a = {a[31], 31'h7FFF_FFFF & (a[31] ? 31'h0 : 31'h7FFF_FFFF)};
      send(3'(i % 8), a, b, tagFor(3'(i % 8)));
    end
    repeat (3) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule